// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the clock line waveform for an I2C master. It drives one output, a pull-down enable for the open-drain SCL pad. The low and high periods are set by three fields: a 4-bit prescale and two 8-bit phase lengths. The time base is the core clock divided by (prescale + 1). The block does not time a phase from its own output. It watches the real bus line through a two-flop synchronizer. The low count starts once the block sees the line low. The high count starts once it sees the line high.

Because the phases are timed from the observed line, other devices on the bus shape the clock. A slave that holds SCL low delays the start of the high count. Another master that pulls the line low during the high count starts the low count at once. A data sequencer can also assert a hold request, which keeps SCL low past the end of the low count until the request drops.

The timing fields must be written while the block is disabled. Deasserting enable releases the line and clears all counting state.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is high or enable is low, `scl_pull` is 0 from the next cycle on. In the cycle after enable is first seen high, the block asserts `scl_pull`.
- R2: Once the synchronized line is seen low while the block is driving low, `scl_pull` stays asserted for exactly NL = (low_len+1)·(presc+1) further cycles. With an otherwise idle bus, each asserted span therefore lasts NL+3 cycles, which includes two synchronizer cycles and one detection cycle.
- R3: After release, once the synchronized line is seen high, the block waits NH = (high_len+1)·(presc+1) cycles before asserting `scl_pull` again. With an otherwise idle bus, each released span lasts NH+3 cycles.
- R4: If another device holds the line low after release, the high count does not start. `scl_pull` rises exactly NH+3 cycles after the line goes high.
- R5: If `hold_req` is high in the last low-count cycle, `scl_pull` stays asserted until the cycle after `hold_req` is seen low. This includes a request raised in exactly that last cycle.
- R6: `hold_req` has no effect while the line is released. The released span stays NH+3 cycles.
- R7: A falling edge on the synchronized line during the high count starts the low count at once, with `scl_pull` rising three cycles after the line falls. This takes priority over a high count that ends in the same cycle. The asserted span that follows lasts exactly NL cycles.
- R8: The field extremes hold. With presc=0, low_len=0 and high_len=0, both spans are 4 cycles. With presc=15, low_len=255 and high_len=255, both spans are 4099 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the clock generator; low releases SCL and clears counters |
| scl_in | input | 1 | Raw SCL line level (synchronized inside) |
| presc | input | 4 | Prescale field; time base is presc+1 core cycles |
| low_len | input | 8 | Low phase length field; low count is low_len+1 time-base units |
| high_len | input | 8 | High phase length field; high count is high_len+1 time-base units |
| hold_req | input | 1 | Data sequencer request to keep SCL low after the low count |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |

## Verification
Two events can land in the same cycle, and the bench times each of them to hit that cycle.

The first is the end of the low count together with a newly raised hold request. The bench raises `hold_req` in the final counting cycle and expects the line to stay held.

The second is the end of the high count together with a falling edge from another master. The bench pulls the line low so that the edge is detected in the final high-count cycle. It then judges the outcome from the next asserted span: it must last NL cycles, not NL+1.

A behavioural reference model, stepped on every clock, cross-checks every cycle of both cases.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_LOW,
        PH_LOW_CNT,
        PH_LOW_HOLD,
        PH_WAIT_HIGH,
        PH_HIGH_CNT
    } scl_phase_e;

    typedef struct packed {
        logic level;
        logic fell;
    } line_view_t;

    function automatic logic phase_drives_low(scl_phase_e p);
        return (p == PH_WAIT_LOW) || (p == PH_LOW_CNT) || (p == PH_LOW_HOLD);
    endfunction

    function automatic logic phase_counts(scl_phase_e p);
        return (p == PH_LOW_CNT) || (p == PH_HIGH_CNT);
    endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync
    import scl_gen_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_raw,
    output line_view_t view
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= line_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    always_comb begin
        view.level = chain_q[LAST];
        view.fell  = prev_q & ~chain_q[LAST];
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int PRESC_W = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    input  logic [CNT_W-1:0]   limit,
    output logic               done
);
    logic [PRESC_W-1:0] pre_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               pre_tick;

    assign pre_tick = (pre_q == presc);
    assign done     = run && pre_tick && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (pre_tick) begin
            pre_q <= '0;
            cnt_q <= cnt_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int PRESC_W     = 4,
    parameter int PHASE_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               scl_in,
    input  logic [PRESC_W-1:0] presc,
    input  logic [PHASE_W-1:0] low_len,
    input  logic [PHASE_W-1:0] high_len,
    input  logic               hold_req,
    output logic               scl_pull
);
    scl_phase_e   state_q, state_n;
    line_view_t   line_v;
    logic         tmr_done;
    logic         tmr_clear;
    logic         tmr_run;
    logic [PHASE_W-1:0] tmr_limit;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_raw (scl_in),
        .view     (line_v)
    );

    scl_phase_timer #(.PRESC_W(PRESC_W), .CNT_W(PHASE_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (tmr_run),
        .presc (presc),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    always_comb begin
        state_n = state_q;
        if (!enable) begin
            state_n = PH_IDLE;
        end else begin
            unique case (state_q)
                PH_IDLE:      state_n = PH_WAIT_LOW;
                PH_WAIT_LOW:  if (!line_v.level) state_n = PH_LOW_CNT;
                PH_LOW_CNT:   if (tmr_done) state_n = hold_req ? PH_LOW_HOLD : PH_WAIT_HIGH;
                PH_LOW_HOLD:  if (!hold_req) state_n = PH_WAIT_HIGH;
                PH_WAIT_HIGH: if (line_v.level) state_n = PH_HIGH_CNT;
                PH_HIGH_CNT: begin
                    if (line_v.fell)   state_n = PH_LOW_CNT;
                    else if (tmr_done) state_n = PH_WAIT_LOW;
                end
                default:      state_n = PH_IDLE;
            endcase
        end
    end

    assign tmr_clear = (state_n != state_q);
    assign tmr_run   = phase_counts(state_q);
    assign tmr_limit = (state_q == PH_LOW_CNT) ? low_len : high_len;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_IDLE;
        else     state_q <= state_n;
    end

    assign scl_pull = phase_drives_low(state_q);
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int PRESC_W = 4,
    parameter int PHASE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               hold_req,
    input logic [PRESC_W-1:0] presc,
    input logic [PHASE_W-1:0] low_len,
    input logic               scl_pull
);
    localparam int RUN_W = PRESC_W + PHASE_W + 2;

    logic [RUN_W-1:0] low_run_q;
    logic [RUN_W-1:0] need;

    assign need = (RUN_W'(low_len) + 1'b1) * (RUN_W'(presc) + 1'b1);

    always_ff @(posedge clk) begin
        if (rst)           low_run_q <= '0;
        else if (scl_pull) low_run_q <= (&low_run_q) ? low_run_q : low_run_q + 1'b1;
        else               low_run_q <= '0;
    end

    // R1
    disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !scl_pull);

    // R1
    pull_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_pull) |-> $past(enable));

    // R5
    release_respects_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_pull) |-> (!$past(hold_req) || !$past(enable)));

    // R2
    low_span_min_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_pull) && $past(enable)) |-> (low_run_q >= need));
endmodule

bind scl_clkgen scl_clkgen_chk #(.PRESC_W(PRESC_W), .PHASE_W(PHASE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .hold_req (hold_req),
    .presc    (presc),
    .low_len  (low_len),
    .scl_pull (scl_pull)
);

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       hold_req = 1'b0;
    logic       slave_low = 1'b0;
    logic       other_low = 1'b0;
    logic [3:0] presc = 4'd1;
    logic [7:0] low_len = 8'd4;
    logic [7:0] high_len = 8'd2;
    logic       scl_pull;
    logic       line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign line = !(scl_pull || slave_low || other_low);

    scl_clkgen u_scl_clkgen (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .scl_in   (line),
        .presc    (presc),
        .low_len  (low_len),
        .high_len (high_len),
        .hold_req (hold_req),
        .scl_pull (scl_pull)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: phases 0 idle, 1 drive, 2 low count,
    // 3 held, 4 released wait, 5 high count; rem counts down cycles left.
    int  m_ph = 0;
    int  m_rem = 0;
    bit  m_s1 = 1, m_s2 = 1, m_prev = 1;
    bit  m_pull;

    function automatic int nl();
        return (int'(low_len) + 1) * (int'(presc) + 1);
    endfunction
    function automatic int nh();
        return (int'(high_len) + 1) * (int'(presc) + 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_rem = 0; m_s1 = 1; m_s2 = 1; m_prev = 1;
        end else begin
            int nx;
            nx = m_ph;
            if (!enable) nx = 0;
            else begin
                case (m_ph)
                    0: nx = 1;
                    1: if (!m_s2) begin nx = 2; m_rem = nl(); end
                    2: begin
                        m_rem--;
                        if (m_rem == 0) nx = hold_req ? 3 : 4;
                    end
                    3: if (!hold_req) nx = 4;
                    4: if (m_s2) begin nx = 5; m_rem = nh(); end
                    5: begin
                        if (m_prev && !m_s2) begin nx = 2; m_rem = nl(); end
                        else begin
                            m_rem--;
                            if (m_rem == 0) nx = 1;
                        end
                    end
                    default: nx = 0;
                endcase
            end
            m_ph = nx;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = line;
        end
    end

    assign m_pull = (m_ph >= 1) && (m_ph <= 3);

    always @(negedge clk) begin
        if (!rst && !done) begin
            string tag;
            case (m_ph)
                0: tag = "R1";
                3: tag = "R5";
                1, 2: tag = "R2";
                default: tag = "R3";
            endcase
            check(scl_pull == m_pull, tag, "per-cycle model compare", scl_pull, m_pull);
        end
    end

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (scl_pull == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic edge_to(input bit lvl);
        @(negedge clk);
        while (scl_pull == lvl) @(negedge clk);
        while (scl_pull != lvl) @(negedge clk);
    endtask

    task automatic reconfig(input int p, input int l, input int h);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        presc = 4'(p); low_len = 8'(l); high_len = 8'(h);
        enable = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check(scl_pull == 1'b0, "R1", "pull during reset", scl_pull, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(scl_pull == 1'b0, "R1", "pull while disabled", scl_pull, 0);

        // R1 start, R2/R3 free run: NL=10, NH=6
        enable = 1'b1;
        @(negedge clk);
        check(scl_pull == 1'b1, "R1", "pull after enable", scl_pull, 1);
        run_len(1'b1, n); check(n == 13, "R2", "first low span", n, 13);
        run_len(1'b0, n); check(n == 9,  "R3", "high span", n, 9);
        run_len(1'b1, n); check(n == 13, "R2", "second low span", n, 13);
        run_len(1'b0, n); check(n == 9,  "R3", "second high span", n, 9);

        // R5: hold raised exactly in the last low-count cycle
        repeat (12) @(negedge clk);
        hold_req = 1'b1;
        repeat (10) @(negedge clk);
        check(scl_pull == 1'b1, "R5", "held past low count", scl_pull, 1);
        hold_req = 1'b0;
        @(negedge clk);
        check(scl_pull == 1'b0, "R5", "release after hold drop", scl_pull, 0);
        run_len(1'b0, n); check(n == 9, "R3", "high span after hold", n, 9);

        // R6: hold while released is ignored
        edge_to(1'b0);
        hold_req = 1'b1;
        run_len(1'b0, n); check(n == 9, "R6", "high span with hold asserted", n, 9);
        hold_req = 1'b0;

        // R4: slave stretches the released line
        edge_to(1'b0);
        slave_low = 1'b1;
        repeat (25) @(negedge clk);
        check(scl_pull == 1'b0, "R4", "released during stretch", scl_pull, 0);
        slave_low = 1'b0;
        n = 0;
        while (scl_pull == 1'b0) begin @(negedge clk); n++; end
        check(n == 9, "R4", "rise after stretch end", n, 9);

        // R1: disable mid-low and re-enable
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_pull == 1'b0, "R1", "release on disable", scl_pull, 0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check(scl_pull == 1'b1, "R1", "pull on re-enable", scl_pull, 1);
        run_len(1'b1, n); check(n == 13, "R2", "low span after re-enable", n, 13);

        // R7: other master pulls low mid high count; NH=62
        reconfig(1, 4, 30);
        edge_to(1'b0);
        repeat (8) @(negedge clk);
        other_low = 1'b1;
        @(negedge clk);
        check(scl_pull == 1'b0, "R7", "no pull one cycle after edge", scl_pull, 0);
        @(negedge clk);
        check(scl_pull == 1'b0, "R7", "no pull two cycles after edge", scl_pull, 0);
        @(negedge clk);
        check(scl_pull == 1'b1, "R7", "pull three cycles after edge", scl_pull, 1);
        other_low = 1'b0;
        run_len(1'b1, n); check(n == 10, "R7", "low span after foreign edge", n, 10);

        // R7: foreign edge in the same cycle the high count ends
        edge_to(1'b0);
        repeat (62) @(negedge clk);
        other_low = 1'b1;
        while (scl_pull == 1'b0) @(negedge clk);
        other_low = 1'b0;
        run_len(1'b1, n); check(n == 10, "R7", "edge wins over high count end", n, 10);

        // R8: field extremes
        reconfig(0, 0, 0);
        check(scl_pull == 1'b1, "R8", "pull after enable, minimum fields", scl_pull, 1);
        run_len(1'b1, n); check(n == 4, "R8", "minimum low span", n, 4);
        run_len(1'b0, n); check(n == 4, "R8", "minimum high span", n, 4);
        reconfig(15, 255, 255);
        run_len(1'b1, n); check(n == 4099, "R8", "maximum low span", n, 4099);
        run_len(1'b0, n); check(n == 4099, "R8", "maximum high span", n, 4099);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule